// File: doc/BRIEF.md
# I2C Target Engine with Sticky Status Flags

This block answers as a target on a two-wire I2C bus with a 7-bit address. It watches SCL and SDA inputs that have already been brought into the clock domain. It pulls SDA low to acknowledge or to send data, and it pulls SCL low to stall the bus while software still has to act. A simple write port sets a four-bit control word, an interrupt enable mask, the own address and a shared data register. A seven-bit status word carries flags that stay set once raised.

Software answers the flags. It takes a received byte from the data register, or it loads the next byte to send, and then it clears the flag by writing 0 to that bit. While a data flag is pending and stalling is enabled, the bus stays stalled until software clears the flag. Software can also refuse a byte. With the forced-NACK control bit set, the byte that completes next is answered with NACK. A general call address (0, write) can be accepted as an option.

Top module: `i2c_target`

## Requirements
- R1: After reset the status word and the interrupt output are 0, and neither SDA nor SCL is pulled.
- R2: Address byte `{addr[6:0], rw}` whose 7 bits equal the own address (write select 3) is acknowledged on the 9th clock. This sets status bit 0, and bit 5 takes the rw value (1 = controller reads). Any other address gets no ACK and sets no flag.
- R3: Address byte 0x00 is acknowledged only when control bit 1 is set. It then sets status bits 0 and 6.
- R4: With control bit 2 (enable) cleared, the block never pulls SDA or SCL and acknowledges nothing.
- R5: A byte received after a write address is stored in the data register (data_o) and sets status bit 1. It is acknowledged when control bit 0 is clear.
- R6: When control bit 0 is set as a received byte completes, that byte is answered with NACK (SDA released on the 9th clock).
- R7: When the address selects read, the data register content is loaded at the address match and sent MSB first. Status bit 3 is set at the match and again after each byte the controller ACKs, when the next byte is loaded from the data register (write select 4). Status bit 2 is set at the end of each sent byte.
- R8: A STOP sets status bit 4 only if the block was addressed since the last START. The block then waits idle for the next START.
- R9: A write to status (select 1) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R10: irq_o is 1 exactly when some status bit and the matching bit of the enable mask (select 2) are both 1.
- R11: With control bit 3 set, SCL is held low after an ACK phase while status bit 1 (in a write) or bit 3 (in a read) is pending, and released once the flag is cleared. With bit 3 clear, SCL is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| scl_pull_o | output | 1 | 1 pulls SCL low (stall) |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK or data 0) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | 0 control, 1 status, 2 enable mask, 3 own address, 4 data |
| wr_data_i | input | 8 | Write data |
| status_o | output | 7 | Sticky status flags |
| data_o | output | 8 | Data register (last received byte or byte to send) |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Each SCL edge passes through one edge-detect register. The engine then registers a set pulse, and the flag register takes it one edge later. So flags, data_o and the SDA drive change within three clock cycles of an SCL edge. The bus model holds every SCL level for ten clock cycles, and every check on status, data_o, SDA or the stall is sampled on a falling clock edge at least a half bit later. The monitor compares data_o against the queued byte on the very cycle status bit 1 rises, which is the cycle the data register is written.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  localparam int DW   = 8;
  localparam int AW   = 7;
  localparam int NS   = 7;
  localparam int SELW = 3;

  // status bit positions
  localparam int SB_ADDR  = 0;
  localparam int SB_RX    = 1;
  localparam int SB_TXD   = 2;
  localparam int SB_EMPTY = 3;
  localparam int SB_STOP  = 4;
  localparam int SB_TXM   = 5;
  localparam int SB_GC    = 6;

  // control bit positions
  localparam int CB_NACK = 0;
  localparam int CB_GC   = 1;
  localparam int CB_EN   = 2;
  localparam int CB_BUF  = 3;

  // write selects
  localparam logic [SELW-1:0] SEL_CTRL = 3'd0;
  localparam logic [SELW-1:0] SEL_STAT = 3'd1;
  localparam logic [SELW-1:0] SEL_IER  = 3'd2;
  localparam logic [SELW-1:0] SEL_OWN  = 3'd3;
  localparam logic [SELW-1:0] SEL_DATA = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } st_e;
endpackage

// File: rtl/i2ct_cond.sv
`timescale 1ns/1ps
module i2ct_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2ct_regs.sv
`timescale 1ns/1ps
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADR_W  = AW,
  parameter int STAT_W = NS,
  parameter int SEL_W  = SELW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              txm_load_i,
  input  logic              txm_val_i,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic [3:0]        ctrl_o,
  output logic [ADR_W-1:0]  own_o,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] ier_q, stat_q;
  logic              wr_stat;

  assign wr_stat = wr_en_i && (wr_sel_i == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      own_o  <= '0;
      ier_q  <= '0;
      data_o <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_CTRL) ctrl_o <= wr_data_i[3:0];
      if (wr_en_i && wr_sel_i == SEL_OWN)  own_o  <= wr_data_i[ADR_W-1:0];
      if (wr_en_i && wr_sel_i == SEL_IER)  ier_q  <= wr_data_i[STAT_W-1:0];
      if (rx_load_i)                               data_o <= rx_byte_i;
      else if (wr_en_i && wr_sel_i == SEL_DATA)    data_o <= wr_data_i;
    end
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           stat_q[i] <= 1'b0;
      else if (i == SB_TXM && txm_load_i)    stat_q[i] <= txm_val_i;
      else if (set_i[i])                     stat_q[i] <= 1'b1;
      else if (wr_stat && !wr_data_i[i])     stat_q[i] <= 1'b0;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & ier_q);

  AST_W0C_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && set_i == '0 && !txm_load_i) |=>
      (stat_q == ($past(stat_q) & $past(wr_data_i[STAT_W-1:0])))); // R9

  AST_IRQ_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_q[SB_RX]) && ier_q[SB_RX]) |-> irq_o); // R10
endmodule

// File: rtl/i2ct_engine.sv
`timescale 1ns/1ps
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADR_W  = AW,
  parameter int STAT_W = NS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gc_en_i,
  input  logic              nack_i,
  input  logic              buf_i,
  input  logic [ADR_W-1:0]  own_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rx_pend_i,
  input  logic              empty_pend_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [STAT_W-1:0] set_o,
  output logic              txm_load_o,
  output logic              txm_val_o,
  output logic              rx_load_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sda_pull_o,
  output logic              scl_pull_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] C_FULL = CW'(DATA_W);
  localparam logic [CW-1:0] C_LAST = CW'(DATA_W - 1);

  st_e               state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              drv_q, sel_q, fresh_q, mack_q, rw_q;
  logic              own_hit, gc_hit;

  assign own_hit = (sh_q[DATA_W-1:1] == own_i);
  assign gc_hit  = gc_en_i && (sh_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      drv_q   <= 1'b0;
      sel_q   <= 1'b0;
      fresh_q <= 1'b0;
      mack_q  <= 1'b0;
      rw_q    <= 1'b0;
      set_o   <= '0;
      txm_load_o <= 1'b0;
      rx_load_o  <= 1'b0;
    end else begin
      set_o      <= '0;
      txm_load_o <= 1'b0;
      rx_load_o  <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        drv_q   <= 1'b0;
        sel_q   <= 1'b0;
        fresh_q <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        drv_q   <= 1'b0;
        sel_q   <= 1'b0;
        fresh_q <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        drv_q   <= 1'b0;
        fresh_q <= 1'b0;
        sel_q   <= 1'b0;
        if (sel_q) set_o[SB_STOP] <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == C_FULL) begin
              if (own_hit || gc_hit) begin
                sel_q   <= 1'b1;
                drv_q   <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_AACK;
                set_o[SB_ADDR] <= 1'b1;
                set_o[SB_GC]   <= gc_hit;
                txm_load_o     <= 1'b1;
                if (sh_q[0]) begin
                  sh_q <= data_i;
                  set_o[SB_EMPTY] <= 1'b1;
                end
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_RACK: begin
            if (scl_fall_i) begin
              drv_q   <= 1'b0;
              cnt_q   <= '0;
              fresh_q <= 1'b1;
              state_q <= (state_q == ST_AACK && rw_q) ? ST_TX : ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q    <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
              fresh_q <= 1'b0;
            end else if (scl_fall_i && cnt_q == C_FULL) begin
              rx_load_o    <= 1'b1;
              set_o[SB_RX] <= 1'b1;
              drv_q        <= !nack_i;
              state_q      <= ST_RACK;
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              fresh_q <= 1'b0;
            end else if (scl_fall_i) begin
              if (cnt_q == C_LAST) begin
                state_q       <= ST_TACK;
                set_o[SB_TXD] <= 1'b1;
              end else begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise_i) begin
              mack_q <= !sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                sh_q    <= data_i;
                cnt_q   <= '0;
                fresh_q <= 1'b1;
                state_q <= ST_TX;
                set_o[SB_EMPTY] <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign txm_val_o  = rw_q;
  assign rx_byte_o  = sh_q;
  assign sda_pull_o = drv_q || (state_q == ST_TX && !sh_q[DATA_W-1]);
  assign scl_pull_o = buf_i && fresh_q &&
                      ((state_q == ST_RX && rx_pend_i) || (state_q == ST_TX && empty_pend_i));

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_i && !start_i) |=> (state_q == ST_IDLE)); // R8

  AST_PULL_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> sel_q); // R2

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sda_pull_o && !scl_pull_o)); // R4

  AST_FORCED_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && !stop_i && state_q == ST_RX && !scl_rise_i && scl_fall_i &&
     cnt_q == C_FULL && nack_i) |=> !sda_pull_o); // R6
endmodule

// File: rtl/i2c_target.sv
`timescale 1ns/1ps
module i2c_target
  import i2ct_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADR_W  = AW,
  parameter int STAT_W = NS,
  parameter int SEL_W  = SELW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o
);
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [3:0]        ctrl;
  logic [ADR_W-1:0]  own;
  logic [STAT_W-1:0] set;
  logic              txm_load, txm_val, rx_load;
  logic [DATA_W-1:0] rx_byte;

  i2ct_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2ct_regs #(.DATA_W(DATA_W), .ADR_W(ADR_W), .STAT_W(STAT_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .set_i(set), .txm_load_i(txm_load), .txm_val_i(txm_val),
    .rx_load_i(rx_load), .rx_byte_i(rx_byte),
    .ctrl_o(ctrl), .own_o(own), .status_o, .data_o, .irq_o
  );

  i2ct_engine #(.DATA_W(DATA_W), .ADR_W(ADR_W), .STAT_W(STAT_W)) u_eng (
    .clk_i, .rst_ni,
    .en_i(ctrl[CB_EN]), .gc_en_i(ctrl[CB_GC]), .nack_i(ctrl[CB_NACK]), .buf_i(ctrl[CB_BUF]),
    .own_i(own), .data_i(data_o),
    .rx_pend_i(status_o[SB_RX]), .empty_pend_i(status_o[SB_EMPTY]),
    .sda_i, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .set_o(set), .txm_load_o(txm_load), .txm_val_o(txm_val),
    .rx_load_o(rx_load), .rx_byte_o(rx_byte),
    .sda_pull_o, .scl_pull_o
  );
endmodule

// File: tb/i2c_target_tb.sv
`timescale 1ns/1ps
module i2c_target_tb;
  localparam int HP = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       scl_pull, sda_pull, irq;
  logic [6:0] status;
  logic [7:0] data;

  wire scl_bus = m_scl & ~scl_pull;
  wire sda_bus = m_sda & ~sda_pull;

  i2c_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .status_o(status), .data_o(data), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_e;
  logic rx_prev = 1'b0;
  logic ack;
  logic [7:0] rb;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare data register when the receive flag rises
  always @(negedge clk) begin
    if (rst_n && status[1] && !rx_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", data, 0);
      else begin
        mon_e = exp_q.pop_front();
        chk(data == mon_e, "R5 received data", data, mon_e);
      end
    end
    rx_prev = status[1];
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [2:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    cyc(2);
  endtask

  task automatic raise();
    int g = 0;
    m_scl = 1'b1;
    while (!scl_bus && g < 5000) begin
      @(posedge clk); #1;
      g++;
    end
    cyc(HP);
  endtask

  task automatic lower();
    m_scl = 1'b0;
    cyc(HP);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; cyc(HP);
    m_sda = 1'b0; cyc(HP);
    lower();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(HP);
    raise();
    m_sda = 1'b1; cyc(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; cyc(HP);
      raise();
      lower();
    end
    m_sda = 1'b1; cyc(HP);
    raise();
    a = ~sda_bus;
    lower();
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(HP);
      raise();
      b[i] = sda_bus;
      lower();
    end
    m_sda = ~give_ack; cyc(HP);
    raise();
    lower();
    m_sda = 1'b1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    smp();
    chk(status == 7'h00, "R1 status after reset", status, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(!sda_pull && !scl_pull, "R1 no pull after reset", {sda_pull, scl_pull}, 0);

    reg_wr(3'd3, 8'h52);
    reg_wr(3'd2, 8'h02);
    reg_wr(3'd0, 8'h0C);

    // R2 mismatch
    bus_start();
    send_byte(8'h60, ack);
    smp(); chk(ack == 1'b0, "R2 foreign address not acked", ack, 0);
    bus_stop();
    smp(); chk(status == 7'h00, "R2/R8 no flags for foreign address", status, 0);

    // R2 / R5 / R10 / R11 write
    bus_start();
    send_byte(8'hA4, ack);
    smp(); chk(ack == 1'b1, "R2 own address acked", ack, 1);
    chk(status == 7'h01, "R2 address flag, write mode", status, 7'h01);
    exp_q.push_back(8'hA5);
    send_byte(8'hA5, ack);
    smp(); chk(ack == 1'b1, "R5 byte acked", ack, 1);
    chk(status == 7'h03, "R5 receive flag", status, 7'h03);
    chk(irq == 1'b1, "R10 irq on enabled flag", irq, 1);
    chk(scl_pull == 1'b1, "R11 SCL held while byte pending", scl_pull, 1);
    reg_wr(3'd1, 8'h7D);
    smp(); chk(status == 7'h01, "R9 only receive flag cleared", status, 7'h01);
    chk(irq == 1'b0, "R10 irq drops", irq, 0);
    chk(scl_pull == 1'b0, "R11 SCL released after clear", scl_pull, 0);

    // R6 forced NACK
    reg_wr(3'd0, 8'h0D);
    exp_q.push_back(8'h3C);
    send_byte(8'h3C, ack);
    smp(); chk(ack == 1'b0, "R6 forced NACK", ack, 0);
    reg_wr(3'd1, 8'h7D);
    reg_wr(3'd0, 8'h0C);
    bus_stop();
    smp(); chk(status == 7'h11, "R8 stop flag after addressed transfer", status, 7'h11);

    // R9 write-zero-to-clear
    reg_wr(3'd1, 8'h7F);
    smp(); chk(status == 7'h11, "R9 ones leave flags", status, 7'h11);
    reg_wr(3'd1, 8'h6F);
    smp(); chk(status == 7'h01, "R9 inverse mask clears one flag", status, 7'h01);
    reg_wr(3'd1, 8'h00);

    // R3 general call
    bus_start();
    send_byte(8'h00, ack);
    smp(); chk(ack == 1'b0, "R3 general call ignored when disabled", ack, 0);
    bus_stop();
    smp(); chk(status == 7'h00, "R3 no flags when disabled", status, 0);
    reg_wr(3'd0, 8'h0E);
    bus_start();
    send_byte(8'h00, ack);
    smp(); chk(ack == 1'b1, "R3 general call acked", ack, 1);
    chk(status == 7'h41, "R3 general call flags", status, 7'h41);
    exp_q.push_back(8'h11);
    send_byte(8'h11, ack);
    reg_wr(3'd2, 8'h00);
    smp(); chk(irq == 1'b0, "R10 masked flags give no irq", irq, 0);
    reg_wr(3'd2, 8'h02);
    reg_wr(3'd1, 8'h7D);
    bus_stop();
    smp(); chk(status == 7'h51, "R8 stop after general call", status, 7'h51);
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd0, 8'h0C);

    // R7 read
    reg_wr(3'd4, 8'hC3);
    bus_start();
    send_byte(8'hA5, ack);
    smp(); chk(ack == 1'b1, "R2 read address acked", ack, 1);
    chk(status == 7'h29, "R7 read mode and empty flag", status, 7'h29);
    chk(scl_pull == 1'b1, "R11 SCL held while empty pending", scl_pull, 1);
    reg_wr(3'd4, 8'h5A);
    reg_wr(3'd1, 8'h77);
    read_byte(1'b1, rb);
    smp(); chk(rb == 8'hC3, "R7 first byte sent", rb, 8'hC3);
    chk(status == 7'h2D, "R7 sent and empty flags", status, 7'h2D);
    chk(scl_pull == 1'b1, "R11 held before next byte", scl_pull, 1);
    reg_wr(3'd1, 8'h77);
    read_byte(1'b0, rb);
    smp(); chk(rb == 8'h5A, "R7 second byte sent", rb, 8'h5A);
    chk(status == 7'h25, "R7 no reload after NACK", status, 7'h25);
    bus_stop();
    smp(); chk(status == 7'h35, "R8 stop after read", status, 7'h35);
    reg_wr(3'd1, 8'h00);

    // R11 no hold with buffer mode off
    reg_wr(3'd0, 8'h04);
    bus_start();
    send_byte(8'hA4, ack);
    exp_q.push_back(8'h66);
    send_byte(8'h66, ack);
    smp(); chk(status == 7'h03, "R5 byte without stall", status, 7'h03);
    chk(scl_pull == 1'b0, "R11 no stall when mode off", scl_pull, 0);
    reg_wr(3'd1, 8'h7D);
    bus_stop();
    reg_wr(3'd1, 8'h00);

    // R4 disabled
    reg_wr(3'd0, 8'h00);
    bus_start();
    send_byte(8'hA4, ack);
    smp(); chk(ack == 1'b0, "R4 disabled target silent", ack, 0);
    bus_stop();
    smp(); chk(status == 7'h00, "R4 no flags when disabled", status, 0);

    cyc(5);
    chk(exp_q.size() == 0, "R5 all queued bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule